// File: doc/BRIEF.md
# Printer Port Register File

This block is the host-facing register file of a standard printer port, with a small emulated printer behind it. The host sees three byte registers at 3-bit offsets: an output/input data register, a status register and a control register. Offsets 3 to 7 are unused.

Bytes leave the block as single-byte stream events. Software writes the data register, then drives the strobe control bit from low to high while the port is selected and not held in init. The byte then appears on a valid/ready output.

Polling the status register steps the emulated printer through its busy and acknowledge handshake. A control write with the strobe bit low can raise a level interrupt. The interrupt is cleared by the next status read. Register accesses take one clock, and read data is registered.

Top module: `pport_regs`

## Requirements
- R1: `addr` selects data (0), status (1) or control (2). A read at offsets 3 to 7 returns 0xFF. A write at offsets 1 and 3 to 7 changes no state.
- R2: A control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R3: A control write with init (bit 2) at 0 sets status to 0xD8.
- R4: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all at 1 clears busy (status bit 7). The data byte is emitted only if the previously stored strobe bit was 0.
- R5: A control write with init and select at 1 and strobe at 0 sets interrupt pending when the previously stored control had the interrupt enable bit (bit 4) at 1.
- R6: `in_load` captures `in_byte` into the input-data register. A data read returns the input-data register when direction (control bit 5) is 1, and the last written data byte otherwise.
- R7: A status read returns the current status and clears interrupt pending. The read then advances the handshake, but only when busy is 0 and the stored strobe is 0:
  - if ack (bit 6) is 1, ack is cleared;
  - otherwise busy and ack are both set.
- R8: Reset sets both data registers to 0xFF, status to 0xD9, control to 0xCC, interrupt pending to 0, `rdata` to 0x00 and `tx_valid` to 0.
- R9: `irq` is a level equal to interrupt pending.
- R10: An emitted byte is held on `tx_data`, with `tx_valid` at 1, until `tx_ready` is seen. Another byte emitted while the slot is still occupied and not being accepted is dropped.
- R11: `rdata` updates on the clock after `rd_en`. It otherwise holds its value. When `wr_en` and `rd_en` are both 1 in the same cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| in_load | input | 1 | Capture `in_byte` into the input-data register |
| in_byte | input | 8 | Input data byte |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Emitted byte is present |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_data | output | 8 | Emitted byte |

## Verification
The hardest situations to reach are the handshake chains that depend on earlier state. Clearing busy needs a strobe-high control write. The ack toggle then needs a strobe-low write followed by status polls. The drop case needs a second emit while `tx_ready` is held low.

Directed sequences build these chains explicitly. Random traffic is biased toward control values with init and select set and toggling strobe, with `tx_ready` randomly withheld. Every access is compared against a bench model of the register state.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int OFF_W  = 3;
    localparam int BYTE_W = 8;

    localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

    localparam int ST_BUSY = 7;
    localparam int ST_ACK  = 6;
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
    localparam logic [BYTE_W-1:0] STAT_FAULT  = 8'hD8;
    localparam logic [BYTE_W-1:0] STAT_RESET  = 8'hD9;
    localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'hCC;
    localparam logic [BYTE_W-1:0] DATA_RESET  = 8'hFF;
    localparam logic [BYTE_W-1:0] UNUSED_READ = 8'hFF;

    typedef struct packed {
        logic load_fault;
        logic clr_busy;
        logic emit;
        logic set_pend;
    } ctrl_effect_t;

    function automatic logic [BYTE_W-1:0] force_ctrl(input logic [BYTE_W-1:0] v);
        return v | CTRL_FORCE;
    endfunction

    function automatic ctrl_effect_t decode_ctrl_write(input logic [BYTE_W-1:0] nv,
                                                       input logic [BYTE_W-1:0] ov);
        ctrl_effect_t e;
        e = '0;
        if (!nv[CT_INIT]) begin
            e.load_fault = 1'b1;
        end else if (nv[CT_SEL]) begin
            if (nv[CT_STB]) begin
                e.clr_busy = 1'b1;
                e.emit     = !ov[CT_STB];
            end else begin
                e.set_pend = ov[CT_IEN];
            end
        end
        return e;
    endfunction

    function automatic logic [BYTE_W-1:0] poll_step(input logic [BYTE_W-1:0] st,
                                                    input logic [BYTE_W-1:0] ct);
        logic [BYTE_W-1:0] r;
        r = st;
        if (!st[ST_BUSY] && !ct[CT_STB]) begin
            if (st[ST_ACK]) begin
                r[ST_ACK] = 1'b0;
            end else begin
                r[ST_ACK]  = 1'b1;
                r[ST_BUSY] = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pport_handshake.sv
module pport_handshake
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_new,
    input  logic [BYTE_W-1:0] ctrl_old,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] status,
    output logic              pending,
    output logic              emit
);
    ctrl_effect_t eff;

    always_comb begin
        eff  = decode_ctrl_write(ctrl_new, ctrl_old);
        emit = ctrl_wr && eff.emit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= STAT_RESET;
            pending <= 1'b0;
        end else if (ctrl_wr) begin
            if (eff.load_fault) begin
                status <= STAT_FAULT;
            end else if (eff.clr_busy) begin
                status[ST_BUSY] <= 1'b0;
            end
            if (eff.set_pend) begin
                pending <= 1'b1;
            end
        end else if (stat_rd) begin
            pending <= 1'b0;
            status  <= poll_step(status, ctrl_old);
        end
    end
endmodule

// File: rtl/pport_tx_slot.sv
module pport_tx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         valid,
    input  logic         ready,
    output logic [W-1:0] data
);
    logic free_now;

    always_comb free_now = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (push && free_now) begin
            valid <= 1'b1;
            data  <= push_data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              in_load,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data
);
    logic [BYTE_W-1:0] out_q;
    logic [BYTE_W-1:0] in_q;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] ctrl_new;
    logic              pend_q;
    logic              emit;
    logic              ctrl_wr;
    logic              stat_rd;
    logic              rd_go;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        ctrl_wr  = wr_en && (addr == OFF_CTRL);
        rd_go    = rd_en && !wr_en;
        stat_rd  = rd_go && (addr == OFF_STAT);
        ctrl_new = force_ctrl(wdata);
        case (addr)
            OFF_DATA: rd_mux = ctrl_q[CT_DIR] ? in_q : out_q;
            OFF_STAT: rd_mux = status_q;
            OFF_CTRL: rd_mux = ctrl_q;
            default:  rd_mux = UNUSED_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= DATA_RESET;
            in_q   <= DATA_RESET;
            ctrl_q <= CTRL_RESET;
            rdata  <= '0;
        end else begin
            if (in_load) in_q <= in_byte;
            if (wr_en && addr == OFF_DATA) out_q <= wdata;
            if (ctrl_wr) ctrl_q <= ctrl_new;
            if (rd_go) rdata <= rd_mux;
        end
    end

    pport_handshake i_hs (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_new (ctrl_new),
        .ctrl_old (ctrl_q),
        .stat_rd  (stat_rd),
        .status   (status_q),
        .pending  (pend_q),
        .emit     (emit)
    );

    pport_tx_slot #(.W(BYTE_W)) i_slot (
        .clk       (clk),
        .rst       (rst),
        .push      (emit),
        .push_data (out_q),
        .valid     (tx_valid),
        .ready     (tx_ready),
        .data      (tx_data)
    );

    always_comb irq = pend_q;
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic [7:0] status_q
);
    a_r2_ctrl_top_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == 3'd2) |=> (rdata[7:6] == 2'b11));

    a_r3_init_low_fault: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd2 && !wdata[2]) |=> (status_q == 8'hD8));

    a_r1_unused_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr >= 3'd3) |=> (rdata == 8'hFF));

    a_r9_irq_cleared_by_poll: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == 3'd1) |=> !irq);

    a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind pport_regs pport_regs_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .status_q (status_q)
);

// File: tb/test_pport_regs.sv
module test_pport_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, in_load = 1'b0, tx_ready = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, in_byte = '0;
    logic [7:0] rdata, tx_data;
    logic       irq, tx_valid;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_out, m_in, m_st, m_ct, m_rd, m_txd;
    logic       m_pend, m_txv;

    always #10 clk = ~clk;

    pport_regs i_pport_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .in_load(in_load), .in_byte(in_byte),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] poll_model(input logic [7:0] st, input logic [7:0] ct);
        logic [7:0] r = st;
        if (!st[7] && !ct[0]) begin
            if (st[6]) r[6] = 1'b0;
            else r = r | 8'hC0;
        end
        return r;
    endfunction

    function automatic logic [7:0] read_model(input logic [2:0] a);
        case (a)
            3'd0: return m_ct[5] ? m_in : m_out;
            3'd1: return m_st;
            3'd2: return m_ct;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        m_out = 8'hFF; m_in = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
        m_rd = 8'h00; m_pend = 1'b0; m_txv = 1'b0; m_txd = 8'h00;
    endtask

    task automatic step(input logic we, input logic re, input logic [2:0] a,
                        input logic [7:0] d, input logic ld, input logic [7:0] ib,
                        input logic rdy, input string tag);
        logic       emit = 1'b0;
        logic [7:0] nv;
        logic [7:0] next_in = m_in;
        string      t;
        wr_en = we; rd_en = re; addr = a; wdata = d; in_load = ld; in_byte = ib; tx_ready = rdy;
        if (ld) next_in = ib;
        if (we) begin
            if (a == 3'd0) m_out = d;
            if (a == 3'd2) begin
                nv = d | 8'hC0;
                if (!nv[2]) m_st = 8'hD8;
                else if (nv[3]) begin
                    if (nv[0]) begin m_st[7] = 1'b0; emit = !m_ct[0]; end
                    else if (m_ct[4]) m_pend = 1'b1;
                end
                m_ct = nv;
            end
        end else if (re) begin
            m_rd = read_model(a);
            if (a == 3'd1) begin m_pend = 1'b0; m_st = poll_model(m_st, m_ct); end
        end
        if (emit && (!m_txv || rdy)) begin m_txv = 1'b1; m_txd = m_out; end
        else if (rdy) m_txv = 1'b0;
        m_in = next_in;
        @(negedge clk);
        if (tag != "") t = tag;
        else if (a == 3'd0) t = "R6";
        else if (a == 3'd1) t = "R7";
        else if (a == 3'd2) t = "R2";
        else t = "R1";
        if (re && !we) check(t, rdata, m_rd);
        else check("R11 rdata hold", rdata, m_rd);
        check("R9 irq", {7'd0, irq}, {7'd0, m_pend});
        check("R10 tx_valid", {7'd0, tx_valid}, {7'd0, m_txv});
        if (m_txv) check("R10 tx_data", tx_data, m_txd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R8 rdata", rdata, 8'h00);
        check("R8 tx_valid", {7'd0, tx_valid}, 8'd0);
        step(0, 1, 3'd1, 0, 0, 0, 0, "R8 status");
        step(0, 1, 3'd2, 0, 0, 0, 0, "R8 control");
        step(0, 1, 3'd0, 0, 0, 0, 0, "R8 data");
        step(1, 0, 3'd5, 8'h12, 0, 0, 0, "R1 write ignored");
        step(0, 1, 3'd6, 0, 0, 0, 0, "R1 unused");
        step(1, 0, 3'd2, 8'h00, 0, 0, 0, "R3 init low");
        step(0, 1, 3'd1, 0, 0, 0, 0, "R3 status");
        step(1, 0, 3'd0, 8'h5A, 0, 0, 0, "R6 data write");
        step(1, 0, 3'd2, 8'h1C, 0, 0, 0, "R5 arm ien");
        step(1, 0, 3'd2, 8'h0D, 0, 0, 0, "R4 strobe rise");
        step(0, 1, 3'd1, 0, 0, 0, 0, "R4 busy clear");
        step(1, 0, 3'd2, 8'h0D, 0, 0, 0, "R4 no re-emit");
        step(1, 0, 3'd2, 8'h1C, 0, 0, 0, "R5 ien set");
        step(1, 0, 3'd2, 8'h0C, 0, 0, 0, "R5 pend");
        step(1, 1, 3'd2, 8'h1D, 0, 0, 0, "R11 write wins");
        step(1, 0, 3'd0, 8'hA7, 0, 0, 0, "R10 second byte");
        step(1, 0, 3'd2, 8'h0C, 0, 0, 0, "R10 strobe low");
        step(1, 0, 3'd2, 8'h0D, 0, 0, 0, "R10 drop while full");
        step(0, 1, 3'd1, 0, 0, 0, 1, "R7 poll");
        step(0, 1, 3'd1, 0, 0, 0, 0, "R7 poll ack");
        step(0, 1, 3'd1, 0, 0, 0, 0, "R7 poll again");
        step(1, 0, 3'd2, 8'h2C, 1, 8'h3E, 0, "R6 dir set");
        step(0, 1, 3'd0, 0, 0, 0, 0, "R6 input byte");
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d = 8'($urandom);
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic       we = ($urandom_range(0, 2) == 0);
            logic       re = ($urandom_range(0, 1) == 0);
            if (a == 3'd2 && $urandom_range(0, 3) != 0) d = (d & 8'h31) | 8'h0C;
            if ($urandom_range(0, 7) == 0) a = 3'd2;
            step(we, re, a, d, ($urandom_range(0, 9) == 0), 8'($urandom),
                 ($urandom_range(0, 2) != 0), "");
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule